// File: doc/BRIEF.md
# Residue-Digit Modular Add/Subtract Unit

This block adds or subtracts two residue digits under one fixed modulus. It is chosen per instance by a parameter, and the result is a reduced digit. It is purely combinational. One instance serves one residue channel of a residue-number-system datapath, such as the per-channel arithmetic of a filter or a stage of a residue-to-binary converter.

Both candidate results are always formed in parallel, the raw one and the corrected one:

- **Addition.** A plain binary add gives the raw sum. A second adder adds the two's-complement image of the modulus to it. The carry out of each adder decides whether the corrected value is taken, so no magnitude comparator is needed.
- **Subtraction.** A binary subtract gives the raw difference. A constant stage adds the modulus back, and the final borrow decides which value is taken.
- **Power-of-two modulus.** The correction stages are left out, and the natural binary wrap is the result.

A small control module turns the carry and borrow flags into two select strobes. A datapath module holds the adders and the output multiplexer.

Top module: `modres_addsub`

## Requirements
- R1: With subSel=0 and both operands below MOD, result equals (opA+opB) mod MOD.
- R2: With subSel=1 and both operands below MOD, result equals (opA-opB+MOD) mod MOD.
- R3: For in-range operands, result is always below MOD.
- R4: On addition the corrected value (sum minus MOD) is selected exactly when the raw sum is at least MOD. A sum of exactly MOD gives 0, and the largest sum 2*MOD-2 gives MOD-2.
- R5: On subtraction the modulus is added back exactly when opA<opB. opA==opB gives 0, and opA>opB gives the plain difference.
- R6: Operand and result width is ceil(log2(MOD)) bits, and the unit is correct for every MOD in {13,11,9,7,5,4}.
- R7: For a power-of-two MOD (4), result is the low bits of the plain binary sum or difference. For example, 3+3 gives 2 and 1-3 gives 2.
- R8: There is no register on any path: result follows a change of opA, opB or subSel without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W = ceil(log2(MOD)) | First residue operand, expected below MOD |
| opB | input | W | Second residue operand, expected below MOD |
| subSel | input | 1 | 0 selects opA+opB, 1 selects opA-opB |
| result | output | W | Reduced result digit |

## Verification
The bench elaborates six copies of the unit side by side, with MOD set to 13, 11, 9, 7, 5 and 4. This covers both generate variants: the constant-correction path for the odd and non-power-of-two moduli, and the bypass for 4. Because every digit space is tiny, all operand pairs under both operations are reachable. A table of directed corner vectors at MOD=13 then pins the exact wrap points. These are a sum of exactly MOD, the largest possible sum, equal operands and the largest borrow.

// File: rtl/modres_pkg.sv
package modres_pkg;

  // Flags raised by the datapath's ripple stages
  typedef struct packed {
    logic sumCarry;   // carry out of raw operand adder
    logic corrCarry;  // carry out of constant correction adder
    logic diffBorrow; // borrow out of raw operand subtractor
  } modFlags_t;

  // Select strobes from control to datapath
  typedef struct packed {
    logic takeDiff;     // route the subtract path to the output
    logic takeAdjusted; // use the corrected value instead of the raw one
  } modStrobe_t;

endpackage

// File: rtl/modres_ctrl.sv
module modres_ctrl
  import modres_pkg::*;
(
  input  logic       subSel,
  input  modFlags_t  flags,
  output modStrobe_t strobe
);

  logic addOverflow;

  // A sum reaches the modulus when the raw add already wrapped the word,
  // or when adding the negated modulus to it wraps.
  always_comb begin
    addOverflow         = flags.sumCarry | flags.corrCarry;
    strobe.takeDiff     = subSel;
    strobe.takeAdjusted = subSel ? flags.diffBorrow : addOverflow;
  end

endmodule

// File: rtl/modres_datapath.sv
module modres_datapath
  import modres_pkg::*;
#(
  parameter  int MOD = 13,
  localparam int W   = $clog2(MOD)
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  modStrobe_t   strobe,
  output modFlags_t    flags,
  output logic [W-1:0] result
);

  localparam logic [W:0] MOD_EXT = (W+1)'(MOD);
  localparam bit         IS_POW2 = ((1 << W) == MOD);

  logic [W:0]   rawSum;
  logic [W:0]   rawDiff;
  logic [W-1:0] sumAdj;
  logic [W-1:0] diffAdj;
  logic         corrCarry;

  assign rawSum  = {1'b0, opA} + {1'b0, opB};
  assign rawDiff = {1'b0, opA} - {1'b0, opB};

  generate
    if (IS_POW2) begin : g_pow2
      // Binary wrap is already the modular result
      assign sumAdj    = rawSum[W-1:0];
      assign diffAdj   = rawDiff[W-1:0];
      assign corrCarry = 1'b0;
    end else begin : g_corr
      localparam logic [W-1:0] NEG_MOD = W'((1 << W) - MOD);
      localparam logic [W-1:0] MOD_LOW = W'(MOD);
      logic [W:0] corrSum;
      assign corrSum   = {1'b0, rawSum[W-1:0]} + {1'b0, NEG_MOD};
      assign sumAdj    = corrSum[W-1:0];
      assign corrCarry = corrSum[W];
      assign diffAdj   = rawDiff[W-1:0] + MOD_LOW;
    end
  endgenerate

  assign flags.sumCarry   = rawSum[W];
  assign flags.corrCarry  = corrCarry;
  assign flags.diffBorrow = rawDiff[W];

  always_comb begin
    if (strobe.takeDiff)
      result = strobe.takeAdjusted ? diffAdj : rawDiff[W-1:0];
    else
      result = strobe.takeAdjusted ? sumAdj : rawSum[W-1:0];

    if (({1'b0, opA} < MOD_EXT) && ({1'b0, opB} < MOD_EXT)) begin
      AST_RESULT_BELOW_MOD: assert ({1'b0, result} < MOD_EXT); // R3
      if (!strobe.takeDiff) begin
        AST_ADD_PICK: assert (strobe.takeAdjusted == (rawSum >= MOD_EXT)); // R4
        AST_ADD_VALUE: assert (int'(result) == (int'(opA) + int'(opB)) % MOD); // R1
      end else begin
        AST_SUB_PICK: assert (strobe.takeAdjusted == (opA < opB)); // R5
        AST_SUB_VALUE: assert (int'(result) == (int'(opA) - int'(opB) + MOD) % MOD); // R2
      end
    end
  end

endmodule

// File: rtl/modres_addsub.sv
module modres_addsub
  import modres_pkg::*;
#(
  parameter  int MOD = 13,
  localparam int W   = $clog2(MOD)
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subSel,
  output logic [W-1:0] result
);

  modFlags_t  flags;
  modStrobe_t strobe;

  modres_ctrl u_ctrl (
    .subSel (subSel),
    .flags  (flags),
    .strobe (strobe)
  );

  modres_datapath #(.MOD(MOD)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .flags  (flags),
    .result (result)
  );

endmodule

// File: tb/sim_modres_addsub.sv
module sim_modres_addsub;

  localparam int CLK_PERIOD = 10;
  localparam int NMOD = 6;
  localparam int MODS [NMOD] = '{13, 11, 9, 7, 5, 4};

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
    logic       sub;
    logic [3:0] exp;
  } vec_t;

  // Corner vectors for MOD=13 (instance 0)
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'd12, 4'd12, 1'b0, 4'd11},  // R4 largest sum
    '{4'd6,  4'd7,  1'b0, 4'd0 },  // R4 sum exactly MOD
    '{4'd6,  4'd6,  1'b0, 4'd12},  // R1 just below MOD
    '{4'd0,  4'd0,  1'b0, 4'd0 },  // R1 zero
    '{4'd12, 4'd1,  1'b0, 4'd0 },  // R4 wrap to zero
    '{4'd3,  4'd5,  1'b1, 4'd11},  // R5 borrow
    '{4'd5,  4'd5,  1'b1, 4'd0 },  // R5 equal
    '{4'd12, 4'd0,  1'b1, 4'd12},  // R5 plain difference
    '{4'd0,  4'd12, 1'b1, 4'd1 },  // R5 largest borrow
    '{4'd9,  4'd4,  1'b1, 4'd5 }   // R2 plain
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] aIn   [NMOD];
  logic [3:0] bIn   [NMOD];
  logic       subIn [NMOD];
  logic [3:0] resOut[NMOD];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NMOD; g++) begin : g_mod
    localparam int WG = $clog2(MODS[g]);
    logic [WG-1:0] r;
    modres_addsub #(.MOD(MODS[g])) u0 (
      .opA    (aIn[g][WG-1:0]),
      .opB    (bIn[g][WG-1:0]),
      .subSel (subIn[g]),
      .result (r)
    );
    assign resOut[g] = 4'(r);
  end

  task automatic check(input string req, input int idx, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s mod %0d: actual %0d expected %0d", req, MODS[idx], got, exp);
    end
  endtask

  task automatic apply(input int idx, input int a, input int b, input bit sub);
    @(negedge clk);
    aIn[idx]   = 4'(a);
    bIn[idx]   = 4'(b);
    subIn[idx] = sub;
    #1;
  endtask

  initial begin
    for (int i = 0; i < NMOD; i++) begin
      aIn[i] = '0; bIn[i] = '0; subIn[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;

    // Reset-time state: zero operands give zero
    for (int i = 0; i < NMOD; i++) check("R1 idle", i, int'(resOut[i]), 0);

    // Table walk on MOD=13
    for (int v = 0; v < NVEC; v++) begin
      apply(0, int'(VECS[v].a), int'(VECS[v].b), VECS[v].sub);
      check(VECS[v].sub ? "R5 table" : "R4 table", 0, int'(resOut[0]), int'(VECS[v].exp));
    end

    // Exhaustive over every modulus (R6), both operations
    for (int i = 0; i < NMOD; i++) begin
      for (int a = 0; a < MODS[i]; a++) begin
        for (int b = 0; b < MODS[i]; b++) begin
          apply(i, a, b, 1'b0);
          check("R1 R6 add", i, int'(resOut[i]), (a + b) % MODS[i]);
          if (int'(resOut[i]) >= MODS[i]) check("R3 range", i, int'(resOut[i]), MODS[i] - 1);
          apply(i, a, b, 1'b1);
          check("R2 R6 sub", i, int'(resOut[i]), (a - b + MODS[i]) % MODS[i]);
          if (int'(resOut[i]) >= MODS[i]) check("R3 range", i, int'(resOut[i]), MODS[i] - 1);
        end
      end
    end

    // Power-of-two modulus wraps naturally
    apply(5, 3, 3, 1'b0);
    check("R7 add", 5, int'(resOut[5]), 2);
    apply(5, 1, 3, 1'b1);
    check("R7 sub", 5, int'(resOut[5]), 2);

    // No clock edge needed: change inputs between edges
    @(posedge clk);
    #2;
    aIn[1] = 4'd10; bIn[1] = 4'd10; subIn[1] = 1'b0;
    #1;
    check("R8 comb", 1, int'(resOut[1]), 9);
    subIn[1] = 1'b1; bIn[1] = 4'd3;
    #1;
    check("R8 comb", 1, int'(resOut[1]), 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule